// File: doc/BRIEF.md
# Four-Channel Direct Memory Access Controller

This block moves bytes between peripherals and memory on an 8-bit processor bus without the processor touching each byte. Each of its four channels owns a 16-bit memory pointer and a 16-bit count word. The upper two bits of the count word choose the kind of transfer. One shared control byte enables channels and selects the end-of-block options. One shared flag byte reports which channels have finished.

While the controller is idle on the bus, the processor reaches its registers through a chip select, a 4-bit register select, an 8-bit data bus and active-low read and write strobes. Each 16-bit register is reached one byte at a time, lower byte first. When an enabled channel sees its request line high, the controller raises a bus request and waits for the grant. It then runs a three-state transfer. In the first state it puts the low address byte on its own pins and the high address byte on the data bus, with a strobe that loads an external latch. In the second and third states it drives the memory and I/O strobes. The two I/O strobes are modelled as input, output and output-enable signal groups.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset, every channel is disabled, so no request raises `hrq`. The output enables `ctl_oe` and `db_oe` are low, `aen` is low, all `dack_n` are high, and the finished-flag byte reads 0.
- R2: `reg_sel[3]`=0 selects a channel register: `reg_sel[2:1]` is the channel, and `reg_sel[0]` is 0 for the address and 1 for the count. A byte pointer steers the next access to the lower byte, then the upper byte, toggling on each such read or write. A write with `reg_sel[3]`=1 sets the pointer back to the lower byte.
- R3: A write with `reg_sel[3]`=1 loads the control byte: bits 3:0 enable channels 3..0, bit 4 turns on auto-reload, and bit 5 turns on stop-at-end. A read with `reg_sel[3]`=1 returns {4'b0, finished flags[3:0]}. A channel whose enable bit is 0 never starts a transfer.
- R4: One cycle after an enabled channel's request is seen, `hrq` rises. No address, strobe or `ctl_oe` activity occurs until `hlda` is high. If no enabled request remains while the controller waits, `hrq` falls.
- R5: When several enabled requests are pending at the grant, the lowest-numbered channel is served. Only the served channel's `dack_n` is low, and only during the transfer states.
- R6: The first transfer cycle lasts one clock. In it `aen`, `ctl_oe`, `adstb` and `db_oe` are high, `addr_lo` holds address bits 7:0, and `db_out` holds address bits 15:8. `adstb` is low in the two cycles that follow.
- R7: In the second and third transfer cycles, count bits 15:14 pick the strobes. 01 drives `ior_n_out` and `memw_n` low. 10 drives `memr_n` and `iow_n_out` low. 00 and 11 drive none.
- R8: After each transfer, the channel's address goes up by 1, and count bits 13:0 go down by 1, wrapping from 0 to 3FFF. Bits 15:14 stay unchanged.
- R9: `tc` is high in the second and third cycles of a transfer whose count field is 0. That transfer sets the channel's finished flag. The flag stays set until a read of the flag byte completes, which clears all flags.
- R10: With bit 5 set, a channel that finishes its block has its enable bit cleared. With bit 5 clear, it stays enabled.
- R11: With bit 4 set, when channel 2 finishes its block, its address and count are loaded from channel 3's registers, and channel 2 stays enabled even when bit 5 is set.
- R12: Outside the transfer cycles, `ctl_oe` and `aen` are low, all `dack_n` are high, and the four strobe outputs rest high.
- R13: Between two transfers the controller spends one cycle waiting with `hrq` still high. If `hlda` is still high and an enabled request remains, the next transfer starts without `hrq` dropping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select for register access, active low |
| reg_sel | input | 4 | Register select |
| db_in | input | 8 | Data bus, incoming side |
| db_out | output | 8 | Data bus, outgoing side: register read data or high address byte |
| db_oe | output | 1 | Data bus output enable |
| ior_n_in | input | 1 | I/O read strobe, incoming side (register read) |
| iow_n_in | input | 1 | I/O write strobe, incoming side (register write) |
| ior_n_out | output | 1 | I/O read strobe, outgoing side |
| iow_n_out | output | 1 | I/O write strobe, outgoing side |
| memr_n | output | 1 | Memory read strobe |
| memw_n | output | 1 | Memory write strobe |
| ctl_oe | output | 1 | Output enable for the four strobes |
| drq | input | 4 | Per-channel transfer requests |
| dack_n | output | 4 | Per-channel acknowledges, active low |
| hrq | output | 1 | Bus request |
| hlda | input | 1 | Bus grant |
| aen | output | 1 | Address enable, high while the block owns the bus |
| adstb | output | 1 | Strobe that loads the high address byte into an external latch |
| addr_lo | output | 8 | Low address byte |
| tc | output | 1 | Pulse marking the last transfer of a block |

## Verification
The assertions assume that every input changes in step with `clk`. They also assume that register accesses happen only while the block is not running a transfer, and that a read or write strobe stays low for at least one clock with the chip select held until one clock after the strobe rises. They further assume that `hlda` rises only after `hrq` has been seen. The bench drives all inputs on the falling clock edge and wraps each register access in a fixed three-cycle task. It raises `hlda` only after it has observed `hrq`, and it never touches the register interface while a transfer is running.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_S1   = 3'd2,
    ST_S2   = 3'd3,
    ST_S3   = 3'd4
  } dma_st_e;

  typedef enum logic [1:0] {
    XF_VERIFY = 2'b00,
    XF_WRITE  = 2'b01,
    XF_READ   = 2'b10,
    XF_RSVD   = 2'b11
  } xfer_e;

  typedef struct packed {
    logic ior_n;
    logic iow_n;
    logic memr_n;
    logic memw_n;
  } strobes_t;

endpackage

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] gnt
);

  // lowest index wins
  generate
    for (genvar i = 0; i < NCH; i++) begin : g_pri
      if (i == 0) begin : g_top
        assign gnt[i] = req[i];
      end else begin : g_low
        assign gnt[i] = req[i] & ~(|req[i-1:0]);
      end
    end
  endgenerate

endmodule

// File: rtl/dma4_regs.sv
module dma4_regs
  import dma4_pkg::*;
#(
  parameter  int NCH   = 4,
  parameter  int CNT_W = 14,
  localparam int CH_W  = $clog2(NCH),
  localparam int SEL_W = CH_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_done,
  input  logic [SEL_W-1:0] sel,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic             xfer_done,
  input  logic [CH_W-1:0]  cur_ch,
  output logic [NCH-1:0]   en,
  output logic [15:0]      cur_addr,
  output logic             cur_zero,
  output xfer_e            cur_type
);

  localparam int  AL_BIT  = NCH;
  localparam int  TCS_BIT = NCH + 1;
  localparam bit  HAS_AL  = (NCH >= 4);
  localparam int  AL_DST  = HAS_AL ? 2 : 0;
  localparam int  AL_SRC  = HAS_AL ? 3 : 0;

  logic [15:0]      addr_q [NCH];
  logic [15:0]      addr_d [NCH];
  logic [15:0]      cnt_q  [NCH];
  logic [15:0]      cnt_d  [NCH];
  logic [7:0]       mode_q, mode_d;
  logic             ptr_q, ptr_d;
  logic [NCH-1:0]   tcf_q, tcf_d;

  logic             is_glob, is_cnt;
  logic [CH_W-1:0]  sel_ch;
  logic [CNT_W-1:0] cur_field;
  logic             al_hit;
  logic [NCH-1:0]   cur_oh;
  logic             upd_en;
  logic [15:0]      rd_word;

  assign is_glob   = sel[SEL_W-1];
  assign is_cnt    = sel[0];
  assign sel_ch    = sel[SEL_W-2:1];
  assign cur_field = cnt_q[cur_ch][CNT_W-1:0];
  assign cur_zero  = (cur_field == '0);
  assign cur_type  = xfer_e'(cnt_q[cur_ch][15:CNT_W]);
  assign cur_addr  = addr_q[cur_ch];
  assign al_hit    = HAS_AL && mode_q[AL_BIT] && (cur_ch == CH_W'(AL_DST));
  assign cur_oh    = NCH'(1) << cur_ch;
  assign en        = mode_q[NCH-1:0];
  assign upd_en    = wr_en | rd_done | xfer_done;

  // next-state
  always_comb begin
    mode_d = mode_q;
    ptr_d  = ptr_q;
    tcf_d  = tcf_q;
    for (int i = 0; i < NCH; i++) begin
      addr_d[i] = addr_q[i];
      cnt_d[i]  = cnt_q[i];
    end
    if (wr_en) begin
      if (is_glob) begin
        mode_d = wdata;
        ptr_d  = 1'b0;
      end else begin
        if (is_cnt) begin
          if (ptr_q) cnt_d[sel_ch][15:8] = wdata;
          else       cnt_d[sel_ch][7:0]  = wdata;
        end else begin
          if (ptr_q) addr_d[sel_ch][15:8] = wdata;
          else       addr_d[sel_ch][7:0]  = wdata;
        end
        ptr_d = ~ptr_q;
      end
    end
    if (rd_done) begin
      if (is_glob) tcf_d = '0;
      else         ptr_d = ~ptr_q;
    end
    if (xfer_done) begin
      addr_d[cur_ch]             = addr_q[cur_ch] + 16'd1;
      cnt_d[cur_ch][CNT_W-1:0]   = cur_field - CNT_W'(1);
      if (cur_zero) begin
        tcf_d = tcf_d | cur_oh;
        if (al_hit) begin
          addr_d[AL_DST] = addr_q[AL_SRC];
          cnt_d[AL_DST]  = cnt_q[AL_SRC];
        end else if (mode_q[TCS_BIT]) begin
          mode_d = mode_q & ~{{(8-NCH){1'b0}}, cur_oh};
        end
      end
    end
  end

  // read mux
  always_comb begin
    rd_word = is_cnt ? cnt_q[sel_ch] : addr_q[sel_ch];
    if (is_glob) rdata = {{(8-NCH){1'b0}}, tcf_q};
    else         rdata = ptr_q ? rd_word[15:8] : rd_word[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ptr_q  <= 1'b0;
      tcf_q  <= '0;
      for (int i = 0; i < NCH; i++) begin
        addr_q[i] <= '0;
        cnt_q[i]  <= '0;
      end
    end else if (upd_en) begin
      mode_q <= mode_d;
      ptr_q  <= ptr_d;
      tcf_q  <= tcf_d;
      for (int i = 0; i < NCH; i++) begin
        addr_q[i] <= addr_d[i];
        cnt_q[i]  <= cnt_d[i];
      end
    end
  end

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !(cur_zero && al_hit)) |=> (cur_addr == $past(cur_addr) + 16'd1));

  // R9
  tc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && cur_zero) |=> ((tcf_q & $past(cur_oh)) != '0));

  // R10
  tc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && cur_zero && !al_hit && mode_q[TCS_BIT]) |=> ((en & $past(cur_oh)) == '0));

  // R11
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && cur_zero && al_hit) |=> (en[AL_DST] && (cur_addr == $past(addr_q[AL_SRC]))));

endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
  import dma4_pkg::*;
#(
  parameter  int NCH  = 4,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  elig,
  input  logic [NCH-1:0]  gnt,
  input  logic            hlda,
  input  xfer_e           xtype,
  input  logic            cnt_zero,
  output logic [CH_W-1:0] cur_ch,
  output logic            xfer_done,
  output logic            hrq,
  output logic            master,
  output logic            adstb,
  output logic            tc,
  output logic [NCH-1:0]  dack_n,
  output strobes_t        strb
);

  dma_st_e         st_q, st_d;
  logic [CH_W-1:0] cur_q;
  logic [CH_W-1:0] gnt_idx;
  logic            any_elig;
  logic            start;
  logic            strobe_on;

  assign any_elig = |elig;
  assign start    = (st_q == ST_WAIT) && hlda && any_elig;

  always_comb begin
    gnt_idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (gnt[i]) gnt_idx = CH_W'(i);
    end
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (any_elig) st_d = ST_WAIT;
      ST_WAIT: begin
        if (!any_elig)  st_d = ST_IDLE;
        else if (hlda)  st_d = ST_S1;
      end
      ST_S1:   st_d = ST_S2;
      ST_S2:   st_d = ST_S3;
      ST_S3:   st_d = ST_WAIT;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cur_q <= '0;
    end else begin
      st_q <= st_d;
      if (start) cur_q <= gnt_idx;
    end
  end

  assign cur_ch    = cur_q;
  assign hrq       = (st_q != ST_IDLE);
  assign master    = (st_q == ST_S1) || (st_q == ST_S2) || (st_q == ST_S3);
  assign adstb     = (st_q == ST_S1);
  assign xfer_done = (st_q == ST_S3);
  assign strobe_on = (st_q == ST_S2) || (st_q == ST_S3);
  assign tc        = strobe_on && cnt_zero;
  assign dack_n    = master ? ~(NCH'(1) << cur_q) : '1;

  always_comb begin
    strb = '1;
    if (strobe_on) begin
      case (xtype)
        XF_WRITE: begin strb.ior_n  = 1'b0; strb.memw_n = 1'b0; end
        XF_READ:  begin strb.memr_n = 1'b0; strb.iow_n  = 1'b0; end
        default:  strb = '1;
      endcase
    end
  end

  // R4
  hlda_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !hlda) |=> !master);

  // R13
  burst_hrq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_S3) |=> hrq);

  // R6
  adstb_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adstb |=> (!adstb && strobe_on));

  // R5
  dack_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dack_n));

  // R7
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((!strb.ior_n && !strb.iow_n) || (!strb.memr_n && !strb.memw_n)));

endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter  int NCH   = 4,
  parameter  int CNT_W = 14,
  localparam int CH_W  = $clog2(NCH),
  localparam int SEL_W = CH_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [7:0]       db_in,
  output logic [7:0]       db_out,
  output logic             db_oe,
  input  logic             ior_n_in,
  input  logic             iow_n_in,
  output logic             ior_n_out,
  output logic             iow_n_out,
  output logic             memr_n,
  output logic             memw_n,
  output logic             ctl_oe,
  input  logic [NCH-1:0]   drq,
  output logic [NCH-1:0]   dack_n,
  output logic             hrq,
  input  logic             hlda,
  output logic             aen,
  output logic             adstb,
  output logic [7:0]       addr_lo,
  output logic             tc
);

  logic [1:0]      rst_sync_q;
  logic            rst_s_n;
  logic            ior_q, iow_q;
  logic            slave_ok, wr_en, rd_done, rd_act;
  logic [7:0]      rdata;
  logic [NCH-1:0]  en, elig, gnt;
  logic [15:0]     cur_addr;
  logic            cur_zero;
  xfer_e           cur_type;
  logic [CH_W-1:0] cur_ch;
  logic            xfer_done, master;
  strobes_t        strb;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ior_q <= 1'b1;
      iow_q <= 1'b1;
    end else begin
      ior_q <= ior_n_in;
      iow_q <= iow_n_in;
    end
  end

  assign slave_ok = !cs_n && !master;
  assign wr_en    = slave_ok && !iow_n_in && iow_q;
  assign rd_done  = slave_ok && ior_n_in && !ior_q;
  assign rd_act   = slave_ok && !ior_n_in;
  assign elig     = drq & en;

  dma4_arb #(.NCH(NCH)) u_arb (
    .req (elig),
    .gnt (gnt)
  );

  dma4_regs #(.NCH(NCH), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .wr_en     (wr_en),
    .rd_done   (rd_done),
    .sel       (reg_sel),
    .wdata     (db_in),
    .rdata     (rdata),
    .xfer_done (xfer_done),
    .cur_ch    (cur_ch),
    .en        (en),
    .cur_addr  (cur_addr),
    .cur_zero  (cur_zero),
    .cur_type  (cur_type)
  );

  dma4_seq #(.NCH(NCH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .elig      (elig),
    .gnt       (gnt),
    .hlda      (hlda),
    .xtype     (cur_type),
    .cnt_zero  (cur_zero),
    .cur_ch    (cur_ch),
    .xfer_done (xfer_done),
    .hrq       (hrq),
    .master    (master),
    .adstb     (adstb),
    .tc        (tc),
    .dack_n    (dack_n),
    .strb      (strb)
  );

  assign db_oe     = adstb || rd_act;
  assign db_out    = adstb ? cur_addr[15:8] : rdata;
  assign addr_lo   = master ? cur_addr[7:0] : 8'h00;
  assign ctl_oe    = master;
  assign aen       = master;
  assign ior_n_out = strb.ior_n;
  assign iow_n_out = strb.iow_n;
  assign memr_n    = strb.memr_n;
  assign memw_n    = strb.memw_n;

  // R6
  adstb_bus_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    adstb |-> (aen && db_oe && !rd_act));

  // R12
  idle_ctl_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !ctl_oe |-> (!aen && (dack_n == '1) && ior_n_out && iow_n_out && memr_n && memw_n));

endmodule

// File: tb/test_dma4_ctrl.sv
module test_dma4_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n;
  logic [3:0] reg_sel;
  logic [7:0] db_in;
  logic [7:0] db_out;
  logic       db_oe;
  logic       ior_n_in, iow_n_in;
  logic       ior_n_out, iow_n_out, memr_n, memw_n, ctl_oe;
  logic [3:0] drq;
  logic [3:0] dack_n;
  logic       hrq, hlda, aen, adstb, tc;
  logic [7:0] addr_lo;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  localparam logic [3:0] SB_WR = 4'b0110;
  localparam logic [3:0] SB_RD = 4'b1001;
  localparam logic [3:0] SB_VF = 4'b1111;
  localparam logic [3:0] SEL_G = 4'b1000;

  always #5 clk = ~clk;

  dma4_ctrl i_dma4_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .reg_sel(reg_sel), .db_in(db_in),
    .db_out(db_out), .db_oe(db_oe), .ior_n_in(ior_n_in), .iow_n_in(iow_n_in),
    .ior_n_out(ior_n_out), .iow_n_out(iow_n_out), .memr_n(memr_n), .memw_n(memw_n),
    .ctl_oe(ctl_oe), .drq(drq), .dack_n(dack_n), .hrq(hrq), .hlda(hlda),
    .aen(aen), .adstb(adstb), .addr_lo(addr_lo), .tc(tc)
  );

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [3:0] sel_a(input int ch);
    return {1'b0, 2'(ch), 1'b0};
  endfunction

  function automatic logic [3:0] sel_c(input int ch);
    return {1'b0, 2'(ch), 1'b1};
  endfunction

  task automatic wr_reg(input logic [3:0] sel, input logic [7:0] v);
    @(negedge clk); cs_n = 1'b0; reg_sel = sel; db_in = v; iow_n_in = 1'b0;
    @(negedge clk); iow_n_in = 1'b1;
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic rd_reg(input logic [3:0] sel, output logic [7:0] v);
    @(negedge clk); cs_n = 1'b0; reg_sel = sel; ior_n_in = 1'b0;
    @(negedge clk); v = db_out; ior_n_in = 1'b1;
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic wr16(input logic [3:0] sel, input logic [15:0] v);
    wr_reg(sel, v[7:0]);
    wr_reg(sel, v[15:8]);
  endtask

  task automatic rd16(input logic [3:0] sel, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_reg(sel, lo);
    rd_reg(sel, hi);
    v = {hi, lo};
  endtask

  function automatic logic [3:0] strobes();
    return {ior_n_out, iow_n_out, memr_n, memw_n};
  endfunction

  // one complete transfer on a single channel, hlda given after hrq
  task automatic xfer(input int ch, input logic [15:0] a, input logic [3:0] sb, input logic tce);
    logic [3:0] dk;
    dk = ~(4'b0001 << ch);
    @(negedge clk); drq[ch] = 1'b1;
    @(negedge clk);
    chk("R4 hrq raised", 16'(hrq), 16'd1);
    chk("R4 no aen before grant", 16'(aen), 16'd0);
    hlda = 1'b1;
    @(negedge clk);
    chk("R6 aen in first cycle", 16'(aen), 16'd1);
    chk("R6 adstb in first cycle", 16'(adstb), 16'd1);
    chk("R6 db_oe in first cycle", 16'(db_oe), 16'd1);
    chk("R6 high address byte", 16'(db_out), 16'(a[15:8]));
    chk("R6 low address byte", 16'(addr_lo), 16'(a[7:0]));
    chk("R5 dack_n", 16'(dack_n), 16'(dk));
    @(negedge clk);
    chk("R7 strobes cycle 2", 16'(strobes()), 16'(sb));
    chk("R9 tc cycle 2", 16'(tc), 16'(tce));
    chk("R6 adstb off", 16'(adstb), 16'd0);
    drq[ch] = 1'b0;
    @(negedge clk);
    chk("R7 strobes cycle 3", 16'(strobes()), 16'(sb));
    @(negedge clk);
    chk("R13 hrq held in wait", 16'(hrq), 16'd1);
    chk("R12 idle outputs", 16'({ctl_oe, strobes(), dack_n}), 16'h00FF);
    @(negedge clk);
    chk("R4 hrq released", 16'(hrq), 16'd0);
    hlda = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] b;
    chk("R1 hrq", 16'(hrq), 16'd0);
    chk("R1 ctl_oe", 16'(ctl_oe), 16'd0);
    chk("R1 db_oe", 16'(db_oe), 16'd0);
    chk("R1 aen", 16'(aen), 16'd0);
    chk("R1 dack_n", 16'(dack_n), 16'h000F);
    chk("R12 strobes idle", 16'(strobes()), 16'h000F);
    rd_reg(SEL_G, b);
    chk("R1 flags clear", 16'(b), 16'd0);
    @(negedge clk); drq = 4'hF;
    repeat (3) begin
      @(negedge clk);
      chk("R3 disabled channels ignore requests", 16'(hrq), 16'd0);
    end
    drq = 4'h0;
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr16(sel_a(0), 16'hBEEF);
    wr16(sel_c(0), 16'h4001);
    rd16(sel_a(0), v);
    chk("R2 address readback", v, 16'hBEEF);
    rd16(sel_c(0), v);
    chk("R2 count readback", v, 16'h4001);
    wr_reg(sel_a(0), 8'h77);
    wr_reg(SEL_G, 8'h00);
    wr16(sel_a(0), 16'h5634);
    rd16(sel_a(0), v);
    chk("R2 pointer reset by control write", v, 16'h5634);
    wr16(sel_a(0), 16'h12AB);
  endtask

  task automatic t_write_tc();
    logic [15:0] v;
    logic [7:0] b;
    wr_reg(SEL_G, 8'h01);
    xfer(0, 16'h12AB, SB_WR, 1'b0);
    rd16(sel_a(0), v);
    chk("R8 address incremented", v, 16'h12AC);
    rd16(sel_c(0), v);
    chk("R8 count decremented", v, 16'h4000);
    xfer(0, 16'h12AC, SB_WR, 1'b1);
    rd16(sel_c(0), v);
    chk("R8 count wraps, type kept", v, 16'h7FFF);
    rd_reg(SEL_G, b);
    chk("R9 flag set", 16'(b), 16'h0001);
    rd_reg(SEL_G, b);
    chk("R9 flag cleared by read", 16'(b), 16'h0000);
    // still enabled without stop-at-end; grant withheld
    @(negedge clk); drq[0] = 1'b1;
    @(negedge clk);
    chk("R10 channel kept enabled", 16'(hrq), 16'd1);
    repeat (4) begin
      @(negedge clk);
      chk("R4 wait for grant", 16'({hrq, aen, ctl_oe}), 16'b100);
    end
    drq[0] = 1'b0;
    @(negedge clk);
    chk("R4 hrq drops without request", 16'(hrq), 16'd0);
  endtask

  task automatic t_types();
    wr16(sel_a(1), 16'h0040);
    wr16(sel_c(1), 16'h8005);
    wr16(sel_a(2), 16'h0100);
    wr16(sel_c(2), 16'h0003);
    wr_reg(SEL_G, 8'h06);
    xfer(1, 16'h0040, SB_RD, 1'b0);
    xfer(2, 16'h0100, SB_VF, 1'b0);
  endtask

  task automatic t_priority_burst();
    wr16(sel_a(0), 16'h2000);
    wr16(sel_c(0), 16'h4005);
    wr_reg(SEL_G, 8'h03);
    @(negedge clk); drq = 4'b0011;
    @(negedge clk);
    chk("R4 hrq", 16'(hrq), 16'd1);
    hlda = 1'b1;
    @(negedge clk);
    chk("R5 channel 0 first", 16'(dack_n), 16'h000E);
    chk("R6 addr ch0", 16'({db_out, addr_lo}), 16'h2000);
    @(negedge clk);
    chk("R7 write strobes", 16'(strobes()), 16'(SB_WR));
    drq[0] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R13 hrq stays in gap", 16'(hrq), 16'd1);
    chk("R13 gap cycle idle", 16'(ctl_oe), 16'd0);
    @(negedge clk);
    chk("R13 next transfer channel 1", 16'(dack_n), 16'h000D);
    chk("R8 addr ch1 advanced", 16'({db_out, addr_lo}), 16'h0041);
    @(negedge clk);
    chk("R7 read strobes", 16'(strobes()), 16'(SB_RD));
    drq[1] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk("R4 hrq released", 16'(hrq), 16'd0);
    hlda = 1'b0;
  endtask

  task automatic t_tc_stop();
    logic [7:0] b;
    wr16(sel_a(0), 16'h3000);
    wr16(sel_c(0), 16'h4000);
    wr_reg(SEL_G, 8'h21);
    xfer(0, 16'h3000, SB_WR, 1'b1);
    @(negedge clk); drq[0] = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R10 stopped channel ignored", 16'(hrq), 16'd0);
    end
    drq[0] = 1'b0;
    rd_reg(SEL_G, b);
    chk("R9 flag ch0", 16'(b), 16'h0001);
  endtask

  task automatic t_reload();
    logic [15:0] v;
    logic [7:0] b;
    wr16(sel_a(3), 16'h5000);
    wr16(sel_c(3), 16'h4002);
    wr16(sel_a(2), 16'h1000);
    wr16(sel_c(2), 16'h4000);
    wr_reg(SEL_G, 8'h34);
    xfer(2, 16'h1000, SB_WR, 1'b1);
    rd16(sel_a(2), v);
    chk("R11 address reloaded", v, 16'h5000);
    rd16(sel_c(2), v);
    chk("R11 count reloaded", v, 16'h4002);
    rd_reg(SEL_G, b);
    chk("R9 flag ch2", 16'(b), 16'h0004);
    @(negedge clk); drq[2] = 1'b1;
    @(negedge clk);
    chk("R11 channel 2 stays enabled", 16'(hrq), 16'd1);
    drq[2] = 1'b0;
    @(negedge clk);
    chk("R4 hrq drops", 16'(hrq), 16'd0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; reg_sel = '0; db_in = '0;
    ior_n_in = 1'b1; iow_n_in = 1'b1; drq = '0; hlda = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_write_tc();
    t_types();
    t_priority_burst();
    t_tc_stop();
    t_reload();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule